// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block copies blocks of memory under the control of two descriptor rings that share a single index. Each source descriptor gives a source address and a byte length. The destination descriptor at the same index gives the destination address. Software fills the descriptors and then advances its own index to hand them to the engine. The engine works through every slot from its own hardware index up to, but not including, the software index. For each slot it moves the data one 32-bit word at a time. It then writes a completion word, carrying a done flag and the length, back into the destination descriptor.

Software controls the engine through a small register window. A run bit gates the start of each new descriptor. A busy bit shows that a descriptor is still in flight, so software can clear run, wait for busy to fall, and know that the engine has drained. An index-reset command returns both indices to slot zero.

Memory is reached through one word-addressed port. The request side is valid/ready: once `mem_req_valid` is raised, the address, write flag and write data stay fixed until the cycle in which `mem_req_ready` is high. Reads get their data on `mem_rsp_valid` at least one cycle after they are accepted. The engine has at most one read outstanding and accepts the response in whatever cycle it arrives. Writes are posted and get no response.

Top module: `desc_copy_engine`

## Requirements
- R1: After reset the control register reads 0, both indices read 0, and `mem_req_valid` is low.
- R2: A descriptor is started only while run is set, the ring size is non-zero and the hardware index differs from the software index. The engine goes idle once the two indices are equal.
- R3: Descriptor i starts at base + 16·i. The word at offset +0 holds the address. The word at offset +4 holds the byte length in bits [29:16].
- R4: A descriptor of length L moves ceil(L/4) words, from source address + 4k to destination address + 4k, in ascending k. Words beyond that count are untouched. A length of 0 moves no data.
- R5: When write-back is enabled, completing a descriptor writes the destination descriptor's word at +4 as the done bit OR (L << 16). The done bit is bit 31 when DONE_HI = 1 and bit 15 otherwise. When write-back is disabled, that word is left unchanged and the index still advances.
- R6: The hardware index advances as (i + 1) AND (size − 1), so it wraps from size − 1 to 0.
- R7: While the ring size register is 0, writes to the software index are ignored (it reads 0) and the engine stays idle.
- R8: Clearing run lets the descriptor in flight finish, busy then falls, and no further descriptor starts until run is set again.
- R9: Writing 1 to bit 0 at offset 0x04 clears both indices when the engine is idle. It is ignored while busy.
- R10: A memory request holds its address, write flag and data stable while valid is high and ready is low.
- R11: The register map is as follows. 0x00 is control: bit 0 is run, bit 1 is write-back enable, bit 8 is busy and read-only. 0x08 is the source ring base. 0x0C is the destination ring base. 0x10 is the ring size. 0x14 is the software index. 0x18 is the hardware index and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The copy path is tried with several kinds of descriptor. A length that is not a multiple of four shows that the word count rounds up and stops without overrun. A zero length shows that the completion write happens even when no data moves. A batch that crosses the end of the ring separates a correct index mask from a plain increment. Running under random back-pressure exposes any request that changes before it is accepted. Other runs cover write-back disabled, run cleared in the middle of a long copy, and an index reset issued while busy. Together these tell apart the stopping rule at a descriptor boundary, the completion-word format, and the rule that refuses to reset while busy.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SRC_ADDR, ST_SRC_LEN, ST_DST_ADDR, ST_RD_DATA, ST_WR_DATA, ST_DONE
  } eng_state_e;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_IRST  = 8'h04;
  localparam logic [7:0] OFF_SBASE = 8'h08;
  localparam logic [7:0] OFF_DBASE = 8'h0C;
  localparam logic [7:0] OFF_COUNT = 8'h10;
  localparam logic [7:0] OFF_SWIDX = 8'h14;
  localparam logic [7:0] OFF_HWIDX = 8'h18;

  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 14;
endpackage

// File: rtl/dce_regs.sv
module dce_regs
  import dce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic [IDX_W-1:0]  hw_idx,
  output logic              run,
  output logic              wb_en,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [IDX_W-1:0]  ring_mask,
  output logic              ring_zero,
  output logic [IDX_W-1:0]  sw_idx,
  output logic              idx_clr
);
  logic [IDX_W:0] count_q;
  logic [IDX_W:0] count_m1;

  assign count_m1  = count_q - 1'b1;
  assign ring_mask = count_m1[IDX_W-1:0];
  assign ring_zero = (count_q == '0);
  assign idx_clr   = wr_en && (addr == OFF_IRST) && wdata[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      wb_en    <= 1'b0;
      src_base <= '0;
      dst_base <= '0;
      count_q  <= '0;
      sw_idx   <= '0;
    end else if (idx_clr) begin
      sw_idx <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_CTRL:  begin run <= wdata[0]; wb_en <= wdata[1]; end
        OFF_SBASE: src_base <= wdata[ADDR_W-1:0];
        OFF_DBASE: dst_base <= wdata[ADDR_W-1:0];
        OFF_COUNT: count_q  <= wdata[IDX_W:0];
        OFF_SWIDX: if (!ring_zero) sw_idx <= wdata[IDX_W-1:0] & ring_mask;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL:  rdata = {23'b0, busy, 6'b0, wb_en, run};
      OFF_SBASE: rdata = 32'(src_base);
      OFF_DBASE: rdata = 32'(dst_base);
      OFF_COUNT: rdata = 32'(count_q);
      OFF_SWIDX: rdata = 32'(sw_idx);
      OFF_HWIDX: rdata = 32'(hw_idx);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dce_mover.sv
module dce_mover
  import dce_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter bit DONE_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [IDX_W-1:0]  ring_mask,
  input  logic              ring_zero,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              idx_clr,
  output logic [IDX_W-1:0]  hw_idx,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int DONE_BIT = DONE_HI ? 31 : 15;
  localparam int WCNT_W   = LEN_W - 1;

  eng_state_e           state;
  logic                 pend;
  logic [ADDR_W-1:0]    src_ptr, dst_ptr, doff;
  logic [LEN_W-1:0]     len_q, len_in;
  logic [WCNT_W-1:0]    words_left;
  logic [LEN_W:0]       len_rnd;
  logic [31:0]          data_q;
  logic                 fire, got;

  assign busy    = (state != ST_IDLE);
  assign doff    = ADDR_W'({hw_idx, 4'b0000});
  assign len_in  = mem_rsp_data[LEN_LSB +: LEN_W];
  assign len_rnd = {1'b0, len_in} + (LEN_W+1)'(3);
  assign fire    = mem_req_valid && mem_req_ready;
  assign got     = pend && mem_rsp_valid;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (state)
      ST_SRC_ADDR: begin mem_req_valid = !pend; mem_req_addr = src_base + doff; end
      ST_SRC_LEN:  begin mem_req_valid = !pend; mem_req_addr = src_base + doff + ADDR_W'(4); end
      ST_DST_ADDR: begin mem_req_valid = !pend; mem_req_addr = dst_base + doff; end
      ST_RD_DATA:  begin mem_req_valid = !pend; mem_req_addr = src_ptr; end
      ST_WR_DATA: begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = dst_ptr; mem_req_wdata = data_q;
      end
      ST_DONE: begin
        mem_req_valid = wb_en; mem_req_we = 1'b1;
        mem_req_addr  = dst_base + doff + ADDR_W'(4);
        mem_req_wdata = (32'(len_q) << LEN_LSB) | (32'd1 << DONE_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= 1'b0;
      hw_idx     <= '0;
      src_ptr    <= '0;
      dst_ptr    <= '0;
      len_q      <= '0;
      words_left <= '0;
      data_q     <= '0;
    end else begin
      if (fire && !mem_req_we) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (idx_clr) hw_idx <= '0;
          else if (run && !ring_zero && (hw_idx != sw_idx)) state <= ST_SRC_ADDR;
        end
        ST_SRC_ADDR: if (got) begin
          pend <= 1'b0; src_ptr <= ADDR_W'(mem_rsp_data); state <= ST_SRC_LEN;
        end
        ST_SRC_LEN: if (got) begin
          pend       <= 1'b0;
          len_q      <= len_in;
          words_left <= len_rnd[LEN_W:2];
          state      <= ST_DST_ADDR;
        end
        ST_DST_ADDR: if (got) begin
          pend    <= 1'b0;
          dst_ptr <= ADDR_W'(mem_rsp_data);
          state   <= (words_left == '0) ? ST_DONE : ST_RD_DATA;
        end
        ST_RD_DATA: if (got) begin
          pend    <= 1'b0;
          data_q  <= mem_rsp_data;
          src_ptr <= src_ptr + ADDR_W'(4);
          state   <= ST_WR_DATA;
        end
        ST_WR_DATA: if (fire) begin
          dst_ptr    <= dst_ptr + ADDR_W'(4);
          words_left <= words_left - 1'b1;
          state      <= (words_left == WCNT_W'(1)) ? ST_DONE : ST_RD_DATA;
        end
        ST_DONE: if (!wb_en || fire) begin
          hw_idx <= (hw_idx + 1'b1) & ring_mask;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine
  import dce_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int RING_MAX = 64,
  parameter bit DONE_HI  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int IDX_W = $clog2(RING_MAX);

  logic              run_w, wb_en_w, ring_zero_w, idx_clr_w, busy_w;
  logic [ADDR_W-1:0] src_base_w, dst_base_w;
  logic [IDX_W-1:0]  ring_mask_w, sw_idx_w, hw_idx_w;

  dce_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w), .hw_idx(hw_idx_w),
    .run(run_w), .wb_en(wb_en_w), .src_base(src_base_w), .dst_base(dst_base_w),
    .ring_mask(ring_mask_w), .ring_zero(ring_zero_w), .sw_idx(sw_idx_w),
    .idx_clr(idx_clr_w)
  );

  dce_mover #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DONE_HI(DONE_HI)) u_mover (
    .clk(clk), .rst_n(rst_n), .run(run_w), .wb_en(wb_en_w),
    .src_base(src_base_w), .dst_base(dst_base_w), .ring_mask(ring_mask_w),
    .ring_zero(ring_zero_w), .sw_idx(sw_idx_w), .idx_clr(idx_clr_w),
    .hw_idx(hw_idx_w), .busy(busy_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              busy,
  input logic              run,
  input logic              ring_zero,
  input logic [IDX_W-1:0]  hw_idx,
  input logic [IDX_W-1:0]  sw_idx,
  input logic [IDX_W-1:0]  ring_mask
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_idle_when_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (hw_idx == sw_idx) |=> !busy);

  assert_zero_ring_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ring_zero |=> !busy);

  assert_no_start_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !run |=> !busy);

  assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_idx != $past(hw_idx)) |->
      (hw_idx == (IDX_W'($past(hw_idx) + 1'b1) & $past(ring_mask))) || (hw_idx == '0));
endmodule

bind desc_copy_engine dce_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .busy(busy_w), .run(run_w), .ring_zero(ring_zero_w), .hw_idx(hw_idx_w),
  .sw_idx(sw_idx_w), .ring_mask(ring_mask_w)
);

// File: tb/desc_copy_engine_bench.sv
module desc_copy_engine_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam int SB = 'h000;
  localparam int DB = 'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_we, mem_rsp_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic        stall = 1'b0;
  logic [7:0]  lf;
  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  desc_copy_engine u_desc_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  assign mem_req_ready = !stall || lf[0];

  always @(posedge clk) begin
    if (!rst_n) begin
      lf <= 8'h5A; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem[mem_req_addr[11:2]] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[11:2]];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_desc(input int i, input int sa, input int len, input int da, input logic [31:0] dw2);
    mem[(SB + 16*i) / 4]     = sa;
    mem[(SB + 16*i) / 4 + 1] = (32'(len) << 16) | 32'h4000_0000;
    mem[(DB + 16*i) / 4]     = da;
    mem[(DB + 16*i) / 4 + 1] = dw2;
  endtask

  task automatic wait_idle();
    logic [31:0] c, h, s;
    for (int n = 0; n < 5000; n++) begin
      rd(8'h00, c); rd(8'h18, h); rd(8'h14, s);
      if (!c[8] && h == s) break;
    end
  endtask

  task automatic chk_copy(input string req, input int sa, input int da, input int len);
    int nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++)
      chk(req, mem[da/4 + k], 32'hC0DE_0000 | 32'(sa/4 + k));
    chk(req, mem[da/4 + nw], SENT);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h18, v); chk("R1 hw idx", v, 0);
    rd(8'h14, v); chk("R1 sw idx", v, 0);
    chk("R1 req idle", 32'(mem_req_valid), 0);
  endtask

  task automatic t_zero_ring();
    logic [31:0] v;
    wr(8'h14, 3);
    rd(8'h14, v); chk("R7 sw idx ignored", v, 0);
    wr(8'h00, 3);
    repeat (20) @(negedge clk);
    rd(8'h00, v); chk("R7 stays idle", 32'(v[8]), 0);
    rd(8'h18, v); chk("R7 hw idx", v, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(8'h08, SB); wr(8'h0C, DB); wr(8'h10, 4);
    rd(8'h08, v); chk("R11 src base", v, SB);
    rd(8'h0C, v); chk("R11 dst base", v, DB);
    rd(8'h10, v); chk("R11 ring size", v, 4);
    set_desc(0, 'h400, 10, 'h800, 0);
    wr(8'h14, 1);
    wait_idle();
    chk_copy("R4 R3 odd length", 'h400, 'h800, 10);
    chk("R5 done word", mem[(DB + 4)/4], 32'h800A_0000);
    rd(8'h18, v); chk("R2 hw idx", v, 1);
  endtask

  task automatic t_stall_wrap();
    logic [31:0] v;
    stall = 1'b1;
    set_desc(1, 'h440, 4, 'h840, 0);
    set_desc(2, 'h460, 0, 'h860, 0);
    set_desc(3, 'h480, 12, 'h880, 0);
    wr(8'h14, 0);
    wait_idle();
    stall = 1'b0;
    chk_copy("R4 R10 stall len4", 'h440, 'h840, 4);
    chk_copy("R4 zero length", 'h460, 'h860, 0);
    chk_copy("R4 R10 stall len12", 'h480, 'h880, 12);
    chk("R5 zero len done", mem[(DB + 32 + 4)/4], 32'h8000_0000);
    chk("R5 done len12", mem[(DB + 48 + 4)/4], 32'h800C_0000);
    rd(8'h18, v); chk("R6 wrapped", v, 0);
  endtask

  task automatic t_no_wb();
    logic [31:0] v;
    set_desc(0, 'h4C0, 8, 'h8C0, 32'h0000_1234);
    wr(8'h00, 1);
    rd(8'h00, v); chk("R11 ctrl", v, 1);
    wr(8'h14, 1);
    wait_idle();
    chk_copy("R4 no-wb copy", 'h4C0, 'h8C0, 8);
    chk("R5 word untouched", mem[(DB + 4)/4], 32'h0000_1234);
    rd(8'h18, v); chk("R5 idx advanced", v, 1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    set_desc(1, 'h500, 128, 'h900, 0);
    set_desc(2, 'h580, 8, 'hA00, 0);
    wr(8'h00, 3);
    wr(8'h14, 3);
    repeat (10) @(negedge clk);
    wr(8'h00, 2);
    wr(8'h04, 1);
    rd(8'h00, v); chk("R8 still busy", 32'(v[8]), 1);
    for (int n = 0; n < 2000; n++) begin
      rd(8'h00, v);
      if (!v[8]) break;
    end
    rd(8'h18, v); chk("R8 one finished", v, 2);
    rd(8'h14, v); chk("R9 reset ignored busy", v, 3);
    chk_copy("R8 in-flight done", 'h500, 'h900, 128);
    repeat (20) @(negedge clk);
    rd(8'h18, v); chk("R8 no restart", v, 2);
    chk("R8 next untouched", mem[(DB + 32 + 4)/4], 0);
    wr(8'h00, 3);
    wait_idle();
    rd(8'h18, v); chk("R8 resumed", v, 3);
    chk("R5 resumed done", mem[(DB + 32 + 4)/4], 32'h8008_0000);
    chk_copy("R4 resumed copy", 'h580, 'hA00, 8);
  endtask

  task automatic t_idx_reset();
    logic [31:0] v;
    wr(8'h04, 1);
    rd(8'h18, v); chk("R9 hw cleared", v, 0);
    rd(8'h14, v); chk("R9 sw cleared", v, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      finish_run();
    end
  end

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] = (w < 128) ? 32'h0 : (w < 512) ? (32'hC0DE_0000 | 32'(w)) : SENT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_ring();
    t_single();
    t_stall_wrap();
    t_no_wb();
    t_stop();
    t_idx_reset();
    finish_run();
  end
endmodule